// File: doc/BRIEF.md
# Multiplexed-Bus Host Register Port

This block is a slave register port that lets an external 8-bit or 16-bit microcontroller reach eight register locations inside the chip. The host bus can carry the address and the data on the same lines, framed by an address-latch strobe, or it can carry them on separate lines. The host can use separate read and write strobes, or a single data strobe with a read/write level. Three static mode pins choose among these bus styles. The host's data lines are modelled as an input bus, an output bus and a per-byte-lane output enable, so that the pad ring can build the tri-state buffers.

Six of the locations are 16-bit data registers. Three of them carry data from the host to the on-chip processor, and three carry data from the processor to the host. The last two locations are read-only status words with a "full" flag for each data register. The host's strobes are asynchronous to the block. Each host access is captured while its strobe is active, then synchronised. It takes effect inside the clock domain when the strobe ends. The processor side uses a simple synchronous address, read-pulse and write-pulse interface.

Top module: `host_reg_port`

## Requirements
- R1: After reset, all data registers and all full flags are zero, and neither output lane is enabled.
- R2: With `mode_mux` high, the low address byte is taken from `h_d_i[7:0]` while `h_ale` is high. It is held after `h_ale` falls, so the same lines can then carry data.
- R3: With `mode_mux` low, the low address byte is taken directly from `h_addr_lo`, and `h_ale` is not used.
- R4: The port is selected only when `h_addr_hi` equals `BASE_HI` (default 0x40) and bits 7:3 of the low address byte equal those of `BASE_LO` (default 0x00). Unselected reads enable no lane, and unselected writes change nothing.
- R5: Low address bits 2:0 choose the location. Locations 0 to 2 are host-to-processor data. Locations 3 to 5 are processor-to-host data. Location 6 returns the host-to-processor full flags in bits 2:0. Location 7 returns the processor-to-host full flags in bits 2:0. All other bits of locations 6 and 7 read zero.
- R6: With `mode_rw` low, `h_rd_ds_n` is an active-low read strobe and `h_wr_rw` is an active-low write strobe. With `mode_rw` high, `h_rd_ds_n` is an active-low data strobe, and `h_wr_rw` selects a read when high and a write when low.
- R7: `h_d_oe` is nonzero only while the port is selected and a read is active. Lane 1 (bits 15:8) is enabled only in 16-bit mode. No lane is enabled during a write.
- R8: With `mode_size8` high, a write stores the low data byte zero-extended to 16 bits, and a read drives only lane 0 with the low byte of the location. With `mode_size8` low, all 16 bits are written and read.
- R9: A host write takes effect after its strobe ends, within five clock cycles. It uses the last address and data seen while the strobe was active.
- R10: A host write to locations 0 to 2 stores the data and sets that location's full flag. A processor read pulse (`p_rd`) at that `p_addr` clears the flag. If both happen in the same cycle, the set wins.
- R11: A processor write (`p_wr`) to locations 3 to 5 stores `p_wdata` and sets that location's full flag. The end of a selected host read of that location clears the flag. If both happen in the same cycle, the set wins.
- R12: Host writes to locations 3 to 7 and processor writes to locations 0 to 2, 6 or 7 have no effect. `p_rdata` always shows the location at `p_addr`, using the same map as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mux | input | 1 | High: address and data share the data lines |
| mode_rw | input | 1 | High: data strobe plus read/write level |
| mode_size8 | input | 1 | High: 8-bit transfers |
| h_addr_hi | input | 8 | Host upper address byte |
| h_addr_lo | input | 8 | Host low address byte (separate-bus mode) |
| h_ale | input | 1 | Address latch enable, active high |
| h_rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| h_wr_rw | input | 1 | Write strobe (active low) or read/write level |
| h_d_i | input | DW | Host data lines, inbound |
| h_d_o | output | DW | Host data lines, outbound |
| h_d_oe | output | 2 | Output enable per byte lane |
| p_addr | input | 3 | Processor location address |
| p_rd | input | 1 | Processor read pulse (clears host-to-processor flag) |
| p_wr | input | 1 | Processor write pulse |
| p_wdata | input | DW | Processor write data |
| p_rdata | output | DW | Contents of location `p_addr` |
| p_in_full | output | 3 | Host-to-processor full flags |
| p_out_full | output | 3 | Processor-to-host full flags |

## Verification
On every cycle, the embedded properties check three things. A committed host write sets the right host-to-processor flag, and a processor read clears it unless a write sets it in the same cycle. A processor write sets its outbound flag. The stored data only changes through the path that owns it, and lane 1 is never driven without lane 0. Only the bench's scenarios can show the bus-level behaviour. These are: address latching versus direct address, the two strobe conventions, byte versus word width and zero-extension, decode rejection, status word contents, and the clearing of an outbound flag by a host read.

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int DW = 16,
  parameter logic [7:0] BASE_HI = 8'h40,
  parameter logic [7:0] BASE_LO = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_mux,
  input  logic          mode_rw,
  input  logic          mode_size8,
  input  logic [7:0]    h_addr_hi,
  input  logic [7:0]    h_addr_lo,
  input  logic          h_ale,
  input  logic          h_rd_ds_n,
  input  logic          h_wr_rw,
  input  logic [DW-1:0] h_d_i,
  output logic [DW-1:0] h_d_o,
  output logic [1:0]    h_d_oe,
  input  logic [2:0]    p_addr,
  input  logic          p_rd,
  input  logic          p_wr,
  input  logic [DW-1:0] p_wdata,
  output logic [DW-1:0] p_rdata,
  output logic [2:0]    p_in_full,
  output logic [2:0]    p_out_full
);
  localparam int BW = DW / 2;
  localparam int NCH = 3;

  function automatic logic [1:0] off3(input logic [2:0] a);
    return (a == 3'd3) ? 2'd0 : (a == 3'd4) ? 2'd1 : 2'd2;
  endfunction

  logic [7:0] lo_lat;
  logic [7:0] lo_eff;
  logic [2:0] loc;
  logic sel, rd_act, wr_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lo_lat <= '0;
    else if (mode_mux && h_ale) lo_lat <= h_d_i[7:0];

  assign lo_eff = mode_mux ? lo_lat : h_addr_lo;
  assign loc    = lo_eff[2:0];
  assign sel    = (h_addr_hi == BASE_HI) && (lo_eff[7:3] == BASE_LO[7:3]);
  assign rd_act = mode_rw ? (!h_rd_ds_n && h_wr_rw)  : !h_rd_ds_n;
  assign wr_act = mode_rw ? (!h_rd_ds_n && !h_wr_rw) : !h_wr_rw;

  logic [DW-1:0] in_reg  [0:NCH-1];
  logic [DW-1:0] out_reg [0:NCH-1];
  logic [NCH-1:0] in_full, out_full;
  logic [DW-1:0] bank [0:7];

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      bank[i]       = in_reg[i];
      bank[i + NCH] = out_reg[i];
    end
    bank[6] = {{(DW-NCH){1'b0}}, in_full};
    bank[7] = {{(DW-NCH){1'b0}}, out_full};
  end

  assign h_d_oe  = {rd_act && sel && !mode_size8, rd_act && sel};
  assign h_d_o   = mode_size8 ? {{BW{1'b0}}, bank[loc][BW-1:0]} : bank[loc];
  assign p_rdata = bank[p_addr];
  assign p_in_full  = in_full;
  assign p_out_full = out_full;

  logic [2:0] wsy, rsy;
  logic wcap_sel, rcap_sel;
  logic [2:0] wcap_loc, rcap_loc;
  logic [DW-1:0] wcap_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wsy <= '0; rsy <= '0;
      wcap_sel <= 1'b0; rcap_sel <= 1'b0;
      wcap_loc <= '0; rcap_loc <= '0;
      wcap_d <= '0;
    end else begin
      wsy <= {wsy[1:0], wr_act};
      rsy <= {rsy[1:0], rd_act};
      if (wr_act) begin
        wcap_sel <= sel;
        wcap_loc <= loc;
        wcap_d   <= h_d_i;
      end
      if (rd_act) begin
        rcap_sel <= sel;
        rcap_loc <= loc;
      end
    end

  logic wr_end, rd_end, hw_in, hr_out, pw_out, pr_in;
  logic [DW-1:0] wdat;

  assign wr_end = wsy[2] && !wsy[1];
  assign rd_end = rsy[2] && !rsy[1];
  assign wdat   = mode_size8 ? {{BW{1'b0}}, wcap_d[BW-1:0]} : wcap_d;
  assign hw_in  = wr_end && wcap_sel && (wcap_loc < 3'd3);
  assign hr_out = rd_end && rcap_sel && (rcap_loc >= 3'd3) && (rcap_loc <= 3'd5);
  assign pw_out = p_wr && (p_addr >= 3'd3) && (p_addr <= 3'd5);
  assign pr_in  = p_rd && (p_addr < 3'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_reg[i]  <= '0;
        out_reg[i] <= '0;
      end
      in_full  <= '0;
      out_full <= '0;
    end else begin
      if (hw_in) in_reg[wcap_loc[1:0]] <= wdat;
      if (pw_out) out_reg[off3(p_addr)] <= p_wdata;
      if (pr_in)  in_full[p_addr[1:0]] <= 1'b0;
      if (hw_in)  in_full[wcap_loc[1:0]] <= 1'b1;
      if (hr_out) out_full[off3(rcap_loc)] <= 1'b0;
      if (pw_out) out_full[off3(p_addr)] <= 1'b1;
    end

  a_r10_set_on_host_write: assert property (@(posedge clk) disable iff (!rst_n)
    hw_in |=> in_full[$past(wcap_loc[1:0])]);

  a_r10_clear_on_proc_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_in && !(hw_in && wcap_loc[1:0] == p_addr[1:0])) |=> !in_full[$past(p_addr[1:0])]);

  a_r11_set_on_proc_write: assert property (@(posedge clk) disable iff (!rst_n)
    pw_out |=> out_full[off3($past(p_addr))]);

  a_r12_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_in |=> ($stable(in_reg[0]) && $stable(in_reg[1]) && $stable(in_reg[2])));

  a_r12_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pw_out |=> ($stable(out_reg[0]) && $stable(out_reg[1]) && $stable(out_reg[2])));

  a_r7_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
    h_d_oe[1] |-> h_d_oe[0]);
endmodule

// File: tb/host_reg_port_tb.sv
`timescale 1ns/1ps
module host_reg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic mode_mux = 1'b1, mode_rw = 1'b0, mode_size8 = 1'b1;
  logic [7:0] h_addr_hi = 8'h00, h_addr_lo = 8'hFF;
  logic h_ale = 1'b0, h_rd_ds_n = 1'b1, h_wr_rw = 1'b1;
  logic [15:0] h_d_i = '0, h_d_o;
  logic [1:0] h_d_oe;
  logic [2:0] p_addr = '0;
  logic p_rd = 1'b0, p_wr = 1'b0;
  logic [15:0] p_wdata = '0, p_rdata;
  logic [2:0] p_in_full, p_out_full;

  host_reg_port dut_i (
    .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux), .mode_rw(mode_rw),
    .mode_size8(mode_size8), .h_addr_hi(h_addr_hi), .h_addr_lo(h_addr_lo),
    .h_ale(h_ale), .h_rd_ds_n(h_rd_ds_n), .h_wr_rw(h_wr_rw), .h_d_i(h_d_i),
    .h_d_o(h_d_o), .h_d_oe(h_d_oe), .p_addr(p_addr), .p_rd(p_rd), .p_wr(p_wr),
    .p_wdata(p_wdata), .p_rdata(p_rdata), .p_in_full(p_in_full),
    .p_out_full(p_out_full));

  int checks = 0, errors = 0;

  typedef struct {
    logic [1:0]  oe;
    logic [15:0] d;
    string       tag;
  } rd_item_t;
  rd_item_t sb[$];
  event sample_ev;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(sample_ev);
    while (sb.size() > 0) begin
      rd_item_t it;
      it = sb.pop_front();
      checks++;
      if (h_d_oe !== it.oe || (it.oe[0] && h_d_o[7:0] !== it.d[7:0]) ||
          (it.oe[1] && h_d_o[15:8] !== it.d[15:8])) begin
        errors++;
        $display("FAIL %s actual oe=%b d=%h expected oe=%b d=%h",
                 it.tag, h_d_oe, h_d_o, it.oe, it.d);
      end
    end
  end

  task automatic host_acc(input bit is_wr, input logic [7:0] hi, input logic [7:0] lo,
                          input logic [15:0] data, input logic [1:0] exp_oe,
                          input logic [15:0] exp_d, input string tag);
    @(negedge clk);
    h_addr_hi = hi;
    if (mode_mux) begin
      h_addr_lo = 8'hFF;
      h_d_i = {8'h00, lo};
      h_ale = 1'b1;
      repeat (2) @(negedge clk);
      h_ale = 1'b0;
    end else begin
      h_addr_lo = lo;
    end
    @(negedge clk);
    h_d_i = is_wr ? data : 16'h0000;
    if (mode_rw) begin
      h_wr_rw = !is_wr;
      h_rd_ds_n = 1'b0;
    end else if (is_wr) h_wr_rw = 1'b0;
    else h_rd_ds_n = 1'b0;
    repeat (3) @(negedge clk);
    if (is_wr) check({tag, " R7 no drive during write"}, {14'd0, h_d_oe}, 16'd0);
    else begin
      rd_item_t it;
      it.oe = exp_oe; it.d = exp_d; it.tag = tag;
      sb.push_back(it);
      -> sample_ev;
    end
    @(negedge clk);
    h_rd_ds_n = 1'b1;
    h_wr_rw = 1'b1;
    repeat (6) @(negedge clk);
    check({tag, " R7 idle no drive"}, {14'd0, h_d_oe}, 16'd0);
  endtask

  task automatic proc_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    p_addr = a; p_wdata = d; p_wr = 1'b1;
    @(negedge clk);
    p_wr = 1'b0;
  endtask

  task automatic proc_rd(input logic [2:0] a);
    @(negedge clk);
    p_addr = a; p_rd = 1'b1;
    @(negedge clk);
    p_rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    p_addr = a;
    #1;
    check(tag, p_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset oe", {14'd0, h_d_oe}, 16'd0);
    rst_n = 1'b1;
    check("R1 reset in_full", {13'd0, p_in_full}, 16'd0);
    check("R1 reset out_full", {13'd0, p_out_full}, 16'd0);
    peek(3'd1, 16'h0000, "R1 reset data");

    host_acc(1, 8'h40, 8'h01, 16'h005A, 2'b00, 16'h0, "R2");
    peek(3'd1, 16'h005A, "R2 R9 latched address write");
    check("R10 flag set", {13'd0, p_in_full}, 16'h0002);
    proc_rd(3'd1);
    @(negedge clk);
    check("R10 flag cleared by proc read", {13'd0, p_in_full}, 16'h0000);

    host_acc(1, 8'h40, 8'h00, 16'h0011, 2'b00, 16'h0, "R10");
    host_acc(0, 8'h40, 8'h06, 16'h0, 2'b01, 16'h0001, "R5 status in");

    proc_wr(3'd4, 16'hBEEF);
    @(negedge clk);
    check("R11 out flag set", {13'd0, p_out_full}, 16'h0002);
    host_acc(0, 8'h40, 8'h07, 16'h0, 2'b01, 16'h0002, "R5 status out");
    host_acc(0, 8'h40, 8'h04, 16'h0, 2'b01, 16'h00EF, "R11 R8 byte read");
    check("R11 out flag cleared by host read", {13'd0, p_out_full}, 16'h0000);

    host_acc(1, 8'h40, 8'h05, 16'h0099, 2'b00, 16'h0, "R12");
    peek(3'd5, 16'h0000, "R12 host write to outbound ignored");
    proc_wr(3'd0, 16'hFFFF);
    peek(3'd0, 16'h0011, "R12 proc write to inbound ignored");

    host_acc(1, 8'h41, 8'h02, 16'h0033, 2'b00, 16'h0, "R4");
    peek(3'd2, 16'h0000, "R4 unselected write ignored");
    check("R4 flags untouched", {13'd0, p_in_full}, 16'h0001);
    host_acc(0, 8'h41, 8'h00, 16'h0, 2'b00, 16'h0, "R4 unselected read");
    host_acc(0, 8'h40, 8'h08, 16'h0, 2'b00, 16'h0, "R4 low byte outside window");

    host_acc(1, 8'h40, 8'h02, 16'hABCD, 2'b00, 16'h0, "R8");
    peek(3'd2, 16'h00CD, "R8 byte write zero-extended");

    mode_size8 = 1'b0;
    host_acc(1, 8'h40, 8'h02, 16'h1234, 2'b00, 16'h0, "R8 word");
    peek(3'd2, 16'h1234, "R8 word write");
    host_acc(0, 8'h40, 8'h02, 16'h0, 2'b11, 16'h1234, "R8 R7 word read");

    mode_rw = 1'b1;
    host_acc(1, 8'h40, 8'h01, 16'h0077, 2'b00, 16'h0, "R6");
    peek(3'd1, 16'h0077, "R6 strobe plus rw write");
    host_acc(0, 8'h40, 8'h01, 16'h0, 2'b11, 16'h0077, "R6 strobe plus rw read");

    mode_rw = 1'b0;
    mode_mux = 1'b0;
    host_acc(1, 8'h40, 8'h00, 16'h2468, 2'b00, 16'h0, "R3");
    peek(3'd0, 16'h2468, "R3 separate bus write");
    host_acc(0, 8'h40, 8'h00, 16'h0, 2'b11, 16'h2468, "R3 separate bus read");
    check("R10 flags after writes", {13'd0, p_in_full}, 16'h0007);

    repeat (4) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule